// File: doc/BRIEF.md
# Configuration Burst SPI Sequencer

This block pushes a complete set of generator-core settings over a four-wire SPI link in one burst. A single-cycle trigger makes it walk a fixed list of 20 register writes. For each write it reads the current value from a parallel settings bus: the frequency words for two channels, amplitude, offset, phase, a relay control byte and eight general-purpose words. Each write goes out as one chip-select frame. The block raises a one-cycle completion pulse after the last frame.

Each frame carries 48 bits, most significant bit first. They are three 16-bit words: the register address, the upper half of the data, then the lower half. The serial clock is the system clock divided by an even parameter, and the link runs in SPI mode 0. A trigger that arrives while a burst is running is remembered. Exactly one further burst follows once the current burst ends.

Top module: `cfg_burst_spi`

## Requirements
- R1: While reset is high and after it is released with no trigger, cs_n is 1, sck is 0, mosi is 0 and done is 0.
- R2: A trigger produces exactly 20 frames whose 8-bit addresses come in this order: 1D, 24, 2B, 2C, 06, 06, 2D, 2E, 02, 01, 04, 03, 2F, 30, 05, 38, 39, 08, 09, 37 (hex).
- R3: Every frame is 48 bits, MSB first: bits 47:40 are zero, bits 39:32 are the address, bits 31:0 are the 32-bit data word. The general-purpose words 0 to 7 go to 1D, 24, 2F, 30, 05, 38, 39 and 37 in that order. Offsets go to 2B/2C, amplitudes to 2D/2E and phases to 08/09 (channel 1 first in each pair).
- R4: The channel 1 frequency is sent as the upper word to 02 and then the lower word to 01. The channel 2 frequency is sent as the upper word to 04 and then the lower word to 03.
- R5: The first write to 06 carries the relay byte with bits 1:0 (the channel 2 bits) forced to zero. The second write carries the full relay byte. Both are zero-extended to 32 bits.
- R6: SPI mode 0 applies. sck is 0 whenever cs_n is 1, mosi changes only when sck falls or at a chip-select edge, and sck rising edges within a frame are SCK_DIV system clocks apart.
- R7: cs_n stays high for at least two sck periods (2*SCK_DIV system clocks) between consecutive frames.
- R8: done is a one-cycle pulse, raised only after the 20th frame's cs_n has returned high, with cs_n high while done is high.
- R9: A trigger during a burst causes exactly one more full burst after the current one. This also holds for a trigger in the cycle done is high. No burst starts without a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst trigger pulse |
| freq1_hi | input | 32 | Channel 1 frequency, upper word |
| freq1_lo | input | 32 | Channel 1 frequency, lower word |
| freq2_hi | input | 32 | Channel 2 frequency, upper word |
| freq2_lo | input | 32 | Channel 2 frequency, lower word |
| ampl1 | input | 32 | Channel 1 amplitude code |
| ampl2 | input | 32 | Channel 2 amplitude code |
| offs1 | input | 32 | Channel 1 offset code |
| offs2 | input | 32 | Channel 2 offset code |
| phase1 | input | 32 | Channel 1 phase code |
| phase2 | input | 32 | Channel 2 phase code |
| relay | input | 8 | Relay byte (bits 3:2 channel 1, bits 1:0 channel 2) |
| misc_words | input | 8x32 | General-purpose words 0..7 |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| done | output | 1 | Burst-complete pulse |

## Verification
Two events can meet in one cycle: a new trigger and the end of a burst. The trigger may be held as pending while the last frame finishes, or it may land in the very cycle done is raised. The bench provokes the first case by pulsing start part way through a burst. It provokes the second by pulsing start on the sample where done is seen high. In both cases it judges the result by counting frames and done pulses over a long idle tail. Exactly 40 decoded frames and two done pulses must appear, never a third burst or a lost one.

// File: rtl/cfg_burst_pkg.sv
package cfg_burst_pkg;
  localparam int NUM_ENTRIES = 20;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int NUM_MISC    = 8;
  localparam int WORD_W      = 16;

  typedef enum logic [3:0] {
    SRC_MISC, SRC_OFFS1, SRC_OFFS2, SRC_RELAY_CH1, SRC_RELAY_ALL,
    SRC_AMPL1, SRC_AMPL2, SRC_F1HI, SRC_F1LO, SRC_F2HI, SRC_F2LO,
    SRC_PH1, SRC_PH2
  } src_e;

  typedef struct packed {
    logic [7:0] addr;
    src_e       src;
    logic [2:0] misc_sel;
  } entry_t;

  // Burst order is behaviour: the receiving core expects this sequence.
  function automatic entry_t entry_of(input logic [IDX_W-1:0] i);
    entry_t e;
    e = '{addr: 8'h00, src: SRC_MISC, misc_sel: 3'd0};
    case (i)
      5'd0:  e = '{8'h1D, SRC_MISC,      3'd0};
      5'd1:  e = '{8'h24, SRC_MISC,      3'd1};
      5'd2:  e = '{8'h2B, SRC_OFFS1,     3'd0};
      5'd3:  e = '{8'h2C, SRC_OFFS2,     3'd0};
      5'd4:  e = '{8'h06, SRC_RELAY_CH1, 3'd0};
      5'd5:  e = '{8'h06, SRC_RELAY_ALL, 3'd0};
      5'd6:  e = '{8'h2D, SRC_AMPL1,     3'd0};
      5'd7:  e = '{8'h2E, SRC_AMPL2,     3'd0};
      5'd8:  e = '{8'h02, SRC_F1HI,      3'd0};
      5'd9:  e = '{8'h01, SRC_F1LO,      3'd0};
      5'd10: e = '{8'h04, SRC_F2HI,      3'd0};
      5'd11: e = '{8'h03, SRC_F2LO,      3'd0};
      5'd12: e = '{8'h2F, SRC_MISC,      3'd2};
      5'd13: e = '{8'h30, SRC_MISC,      3'd3};
      5'd14: e = '{8'h05, SRC_MISC,      3'd4};
      5'd15: e = '{8'h38, SRC_MISC,      3'd5};
      5'd16: e = '{8'h39, SRC_MISC,      3'd6};
      5'd17: e = '{8'h08, SRC_PH1,       3'd0};
      5'd18: e = '{8'h09, SRC_PH2,       3'd0};
      5'd19: e = '{8'h37, SRC_MISC,      3'd7};
      default: e = '{8'h00, SRC_MISC,    3'd0};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/cfg_entry_mux.sv
module cfg_entry_mux
  import cfg_burst_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RELAY_W  = 8,
  parameter logic [RELAY_W-1:0] CH2_MASK = 8'h03,
  localparam int FRAME_W = WORD_W + DATA_W
) (
  input  logic [IDX_W-1:0]                 idx,
  input  logic [DATA_W-1:0]                freq1_hi,
  input  logic [DATA_W-1:0]                freq1_lo,
  input  logic [DATA_W-1:0]                freq2_hi,
  input  logic [DATA_W-1:0]                freq2_lo,
  input  logic [DATA_W-1:0]                ampl1,
  input  logic [DATA_W-1:0]                ampl2,
  input  logic [DATA_W-1:0]                offs1,
  input  logic [DATA_W-1:0]                offs2,
  input  logic [DATA_W-1:0]                phase1,
  input  logic [DATA_W-1:0]                phase2,
  input  logic [RELAY_W-1:0]               relay,
  input  logic [NUM_MISC-1:0][DATA_W-1:0]  misc_words,
  output logic [FRAME_W-1:0]               frame
);
  entry_t            ent;
  logic [DATA_W-1:0] data;

  always_comb begin
    ent = entry_of(idx);
    case (ent.src)
      SRC_OFFS1:     data = offs1;
      SRC_OFFS2:     data = offs2;
      SRC_RELAY_CH1: data = DATA_W'(relay & ~CH2_MASK);
      SRC_RELAY_ALL: data = DATA_W'(relay);
      SRC_AMPL1:     data = ampl1;
      SRC_AMPL2:     data = ampl2;
      SRC_F1HI:      data = freq1_hi;
      SRC_F1LO:      data = freq1_lo;
      SRC_F2HI:      data = freq2_hi;
      SRC_F2LO:      data = freq2_lo;
      SRC_PH1:       data = phase1;
      SRC_PH2:       data = phase2;
      default:       data = misc_words[ent.misc_sel];
    endcase
    frame = {WORD_W'(ent.addr), data};
  end
endmodule

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter #(
  parameter int FRAME_W = 48,
  parameter int SCK_DIV = 4,
  parameter int GAP_SCK = 2,
  localparam int HALF    = SCK_DIV / 2,
  localparam int DIV_W   = $clog2(HALF + 1),
  localparam int HCNT_W  = $clog2(2 * FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               sck,
  output logic               mosi,
  output logic               cs_n,
  output logic               frame_done
);
  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_TAIL, SH_GAP} sh_e;

  localparam logic [HCNT_W-1:0] LAST_HALF = HCNT_W'(2 * FRAME_W - 1);
  localparam logic [HCNT_W-1:0] LAST_GAP  = HCNT_W'(2 * GAP_SCK - 1);
  localparam logic [DIV_W-1:0]  DIV_TOP   = DIV_W'(HALF - 1);

  sh_e                state;
  logic [DIV_W-1:0]   div;
  logic [HCNT_W-1:0]  hcnt;
  logic [FRAME_W-1:0] sreg;
  logic               tick;

  assign tick = (div == DIV_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SH_IDLE;
      div        <= '0;
      hcnt       <= '0;
      sreg       <= '0;
      sck        <= 1'b0;
      mosi       <= 1'b0;
      cs_n       <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (state == SH_IDLE) div <= '0;
      else                  div <= tick ? '0 : div + 1'b1;
      case (state)
        SH_IDLE: if (load) begin
          sreg  <= frame;
          mosi  <= frame[FRAME_W-1];
          cs_n  <= 1'b0;
          hcnt  <= '0;
          state <= SH_SHIFT;
        end
        SH_SHIFT: if (tick) begin
          hcnt <= hcnt + 1'b1;
          if (!hcnt[0]) begin
            sck <= 1'b1;
          end else begin
            sck <= 1'b0;
            if (hcnt == LAST_HALF) begin
              state <= SH_TAIL;
            end else begin
              sreg <= sreg << 1;
              mosi <= sreg[FRAME_W-2];
            end
          end
        end
        SH_TAIL: if (tick) begin
          cs_n  <= 1'b1;
          mosi  <= 1'b0;
          hcnt  <= '0;
          state <= SH_GAP;
        end
        default: if (tick) begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == LAST_GAP) begin
            state      <= SH_IDLE;
            frame_done <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_burst_seq.sv
module cfg_burst_seq
  import cfg_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             frame_done,
  output logic [IDX_W-1:0] idx,
  output logic             load,
  output logic             done
);
  typedef enum logic {Q_IDLE, Q_RUN} q_e;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  q_e   state;
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= Q_IDLE;
      pend  <= 1'b0;
      idx   <= '0;
      load  <= 1'b0;
      done  <= 1'b0;
    end else begin
      load <= 1'b0;
      done <= 1'b0;
      case (state)
        Q_IDLE: if (start || pend) begin
          idx   <= '0;
          load  <= 1'b1;
          pend  <= 1'b0;
          state <= Q_RUN;
        end
        default: begin
          if (start) pend <= 1'b1;
          if (frame_done) begin
            if (idx == LAST_IDX) begin
              done  <= 1'b1;
              state <= Q_IDLE;
            end else begin
              idx  <= idx + 1'b1;
              load <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_burst_spi.sv
module cfg_burst_spi
  import cfg_burst_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RELAY_W = 8,
  parameter int SCK_DIV = 4,
  parameter int GAP_SCK = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [DATA_W-1:0]                freq1_hi,
  input  logic [DATA_W-1:0]                freq1_lo,
  input  logic [DATA_W-1:0]                freq2_hi,
  input  logic [DATA_W-1:0]                freq2_lo,
  input  logic [DATA_W-1:0]                ampl1,
  input  logic [DATA_W-1:0]                ampl2,
  input  logic [DATA_W-1:0]                offs1,
  input  logic [DATA_W-1:0]                offs2,
  input  logic [DATA_W-1:0]                phase1,
  input  logic [DATA_W-1:0]                phase2,
  input  logic [RELAY_W-1:0]               relay,
  input  logic [NUM_MISC-1:0][DATA_W-1:0]  misc_words,
  output logic                             sck,
  output logic                             mosi,
  output logic                             cs_n,
  output logic                             done
);
  localparam int FRAME_W = WORD_W + DATA_W;

  logic [IDX_W-1:0]   idx;
  logic               load;
  logic               frame_done;
  logic [FRAME_W-1:0] frame;

  cfg_burst_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .frame_done(frame_done),
    .idx(idx), .load(load), .done(done)
  );

  cfg_entry_mux #(.DATA_W(DATA_W), .RELAY_W(RELAY_W)) u_mux (
    .idx(idx), .freq1_hi(freq1_hi), .freq1_lo(freq1_lo),
    .freq2_hi(freq2_hi), .freq2_lo(freq2_lo), .ampl1(ampl1), .ampl2(ampl2),
    .offs1(offs1), .offs2(offs2), .phase1(phase1), .phase2(phase2),
    .relay(relay), .misc_words(misc_words), .frame(frame)
  );

  cfg_spi_shifter #(.FRAME_W(FRAME_W), .SCK_DIV(SCK_DIV), .GAP_SCK(GAP_SCK)) u_shift (
    .clk(clk), .rst(rst), .load(load), .frame(frame),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .frame_done(frame_done)
  );
endmodule

// File: rtl/cfg_burst_spi_chk.sv
module cfg_burst_spi_chk #(
  parameter int SCK_DIV = 4,
  localparam int GAP_MIN = 2 * SCK_DIV,
  localparam int GW      = $clog2(GAP_MIN + 1)
) (
  input logic clk,
  input logic rst,
  input logic sck,
  input logic mosi,
  input logic cs_n,
  input logic done
);
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst)                      gap_cnt <= GW'(GAP_MIN);
    else if (!cs_n)               gap_cnt <= '0;
    else if (gap_cnt < GW'(GAP_MIN)) gap_cnt <= gap_cnt + 1'b1;
  end

  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  assert_mosi_edge_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> ($fell(sck) || $fell(cs_n) || cs_n));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (gap_cnt >= GW'(GAP_MIN)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_cs_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> cs_n);
endmodule

bind cfg_burst_spi cfg_burst_spi_chk #(.SCK_DIV(SCK_DIV)) u_chk (
  .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cs_n(cs_n), .done(done)
);

// File: tb/test_cfg_burst_spi.sv
`timescale 1ns/1ps
module test_cfg_burst_spi;
  localparam int SCK_DIV = 4;
  localparam time TCLK   = 10ns;

  logic clk = 1'b0;
  logic rst, start;
  logic [31:0] f1h, f1l, f2h, f2l, a1, a2, o1, o2, p1, p2;
  logic [7:0]  rly;
  logic [7:0][31:0] misc;
  logic sck, mosi, cs_n, done;

  int n_chk = 0, n_fail = 0;
  int fcount = 0, done_cnt = 0;

  always #(TCLK/2) clk = ~clk;

  cfg_burst_spi #(.SCK_DIV(SCK_DIV)) i_cfg_burst_spi (
    .clk(clk), .rst(rst), .start(start),
    .freq1_hi(f1h), .freq1_lo(f1l), .freq2_hi(f2h), .freq2_lo(f2l),
    .ampl1(a1), .ampl2(a2), .offs1(o1), .offs2(o2),
    .phase1(p1), .phase2(p2), .relay(rly), .misc_words(misc),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_frame(input int i);
    logic [7:0] a; logic [31:0] d;
    case (i)
      0:  begin a = 8'h1D; d = misc[0]; end
      1:  begin a = 8'h24; d = misc[1]; end
      2:  begin a = 8'h2B; d = o1; end
      3:  begin a = 8'h2C; d = o2; end
      4:  begin a = 8'h06; d = {24'h0, rly[7:2], 2'b00}; end
      5:  begin a = 8'h06; d = {24'h0, rly}; end
      6:  begin a = 8'h2D; d = a1; end
      7:  begin a = 8'h2E; d = a2; end
      8:  begin a = 8'h02; d = f1h; end
      9:  begin a = 8'h01; d = f1l; end
      10: begin a = 8'h04; d = f2h; end
      11: begin a = 8'h03; d = f2l; end
      12: begin a = 8'h2F; d = misc[2]; end
      13: begin a = 8'h30; d = misc[3]; end
      14: begin a = 8'h05; d = misc[4]; end
      15: begin a = 8'h38; d = misc[5]; end
      16: begin a = 8'h39; d = misc[6]; end
      17: begin a = 8'h08; d = p1; end
      18: begin a = 8'h09; d = p2; end
      default: begin a = 8'h37; d = misc[7]; end
    endcase
    return {8'h00, a, d};
  endfunction

  function automatic string tag_of(input int i);
    if (i == 4 || i == 5) return "R5";
    if (i >= 8 && i <= 11) return "R4";
    return "R3";
  endfunction

  // SPI slave model
  logic [47:0] rx;
  int  rx_bits = 0;
  time last_rise = 0, cs_rise_t = 0;
  bit  in_frame = 0, cs_seen = 0, per_bad = 0, mosi_bad = 0, idle_bad = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0;

  always @(negedge cs_n) begin
    if (!rst) begin
      rx_bits = 0; per_bad = 0; mosi_bad = 0; in_frame = 1;
      if (sck !== 1'b0) per_bad = 1;
      if (cs_seen)
        chk(($time - cs_rise_t) >= 2*SCK_DIV*TCLK, "R7", "cs_n high gap (ns)",
            64'($time - cs_rise_t), 64'(2*SCK_DIV*TCLK));
    end
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      if (rx_bits > 0 && ($time - last_rise) != SCK_DIV*TCLK) per_bad = 1;
      last_rise = $time;
      rx = {rx[46:0], mosi};
      rx_bits++;
    end
  end

  always @(negedge clk) begin
    if (sck === 1'b1 && prev_sck === 1'b1 && mosi !== prev_mosi) mosi_bad = 1;
    if (cs_n === 1'b1 && sck !== 1'b0) idle_bad = 1;
    prev_sck = sck; prev_mosi = mosi;
  end

  always @(posedge cs_n) begin
    if (in_frame) begin
      int fi;
      logic [47:0] e;
      in_frame = 0;
      fi = fcount % 20;
      e  = exp_frame(fi);
      chk(rx_bits == 48, "R3", "frame bit count", 64'(rx_bits), 64'd48);
      chk(rx[47:32] == e[47:32], "R2", $sformatf("address of entry %0d", fi),
          64'(rx[47:32]), 64'(e[47:32]));
      chk(rx[31:0] == e[31:0], tag_of(fi), $sformatf("data of entry %0d", fi),
          64'(rx[31:0]), 64'(e[31:0]));
      chk(!per_bad && !mosi_bad && !idle_bad, "R6", "mode 0 timing flags",
          64'({per_bad, mosi_bad, idle_bad}), 64'd0);
      fcount++;
      cs_rise_t = $time;
      cs_seen = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && done === 1'b1) begin
      done_cnt++;
      chk((fcount % 20 == 0) && fcount > 0 && cs_n === 1'b1, "R8",
          "frames seen at done", 64'(fcount), 64'(((fcount + 19) / 20) * 20));
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input int target);
    int cyc = 0;
    while (done_cnt < target && cyc < 40000) begin
      @(negedge clk); cyc++;
    end
    chk(done_cnt >= target, "R8", "done reached", 64'(done_cnt), 64'(target));
  endtask

  task automatic rand_settings();
    f1h = $urandom(); f1l = $urandom(); f2h = $urandom(); f2l = $urandom();
    a1 = $urandom(); a2 = $urandom(); o1 = $urandom(); o2 = $urandom();
    p1 = $urandom(); p2 = $urandom(); rly = 8'($urandom());
    for (int k = 0; k < 8; k++) misc[k] = $urandom();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(180000 * TCLK);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base_d, base_f;
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0;
    f1h = 32'h0BEE32EF; f1l = 32'h0000AB5C; f2h = 32'h000186A0; f2l = 32'h0;
    a1 = 32'h0E65; a2 = 32'h0E65; o1 = 32'h07FF; o2 = 32'h07FF;
    p1 = 32'h000FFFFF; p2 = 32'h000FFFFF; rly = 8'hC7;
    for (int k = 0; k < 8; k++) misc[k] = 32'h1111_0000 * (k + 1) + k;
    repeat (4) @(negedge clk);
    chk({cs_n, sck, mosi, done} == 4'b1000, "R1", "outputs in reset",
        64'({cs_n, sck, mosi, done}), 64'b1000);
    rst = 1'b0;
    repeat (50) @(negedge clk);
    chk({cs_n, sck, mosi, done} == 4'b1000 && fcount == 0, "R1", "idle after reset",
        64'({cs_n, sck, mosi, done}), 64'b1000);

    // Directed burst; relay C7 exercises R5 masking of bits 1:0
    pulse_start(); wait_done(1);
    chk(fcount == 20, "R2", "frames in first burst", 64'(fcount), 64'd20);

    // Extremes: all ones and all zeros
    f1h = '1; f1l = '1; f2h = '1; f2l = '1; a1 = '1; a2 = '1; o1 = '1; o2 = '1;
    p1 = '1; p2 = '1; rly = 8'hFF; for (int k = 0; k < 8; k++) misc[k] = '1;
    pulse_start(); wait_done(2);
    f1h = '0; f1l = '0; f2h = '0; f2l = '0; a1 = '0; a2 = '0; o1 = '0; o2 = '0;
    p1 = '0; p2 = '0; rly = 8'h03; for (int k = 0; k < 8; k++) misc[k] = '0;
    pulse_start(); wait_done(3);

    // Random bursts
    for (int b = 0; b < 3; b++) begin
      rand_settings(); pulse_start(); wait_done(4 + b);
    end
    chk(fcount == 120, "R2", "frames after six bursts", 64'(fcount), 64'd120);

    // R9: trigger during a burst is held for one extra burst
    rand_settings();
    base_d = done_cnt; base_f = fcount;
    pulse_start();
    repeat (700) @(negedge clk);
    pulse_start();
    wait_done(base_d + 2);
    repeat (3000) @(negedge clk);
    chk(done_cnt == base_d + 2, "R9", "done pulses for held trigger",
        64'(done_cnt), 64'(base_d + 2));
    chk(fcount == base_f + 40, "R9", "frames for held trigger",
        64'(fcount), 64'(base_f + 40));

    // R9: trigger in the same cycle done is high
    rand_settings();
    base_d = done_cnt; base_f = fcount;
    pulse_start();
    while (done !== 1'b1) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(base_d + 2);
    repeat (3000) @(negedge clk);
    chk(done_cnt == base_d + 2, "R9", "done pulses for coincident trigger",
        64'(done_cnt), 64'(base_d + 2));
    chk(fcount == base_f + 40, "R9", "frames for coincident trigger",
        64'(fcount), 64'(base_f + 40));
    chk(cs_n === 1'b1 && sck === 1'b0, "R6", "idle lines at end",
        64'({cs_n, sck}), 64'b10);
    finish_run();
  end
endmodule